// File: doc/BRIEF.md
# Segmented Physical Address Generator with Byte-Wide Bus Sequencer

This unit turns a segment-relative memory request into accesses on an 8-bit external bus. Four 16-bit segment registers each give a base aligned to 16 bytes. The physical address is the selected segment shifted left by four, plus a 16-bit offset, truncated to 20 bits. The access type picks the segment: code for instruction fetches and control transfers, data for ordinary loads and stores, stack for stack traffic and return addresses, and extra for explicit use.

A request is accepted in any cycle when the unit is idle. It carries the access type, the offset, a byte/word flag, a direction and write data. A byte takes one bus cycle. A word takes two, low byte first. Every bus cycle holds a request line until the bus acknowledges it. A request can also be marked far. The unit then saves the selected segment register, loads a supplied segment value, performs the access through it and puts the saved value back before it signals completion.

Software and control logic load segment registers through a dedicated write port. A load that arrives during a transfer is held and applied when that transfer finishes. A read port shows the current contents of any register.

Top module: `seg_addr_unit`

## Requirements
- R1: The bus address equals (segment << 4) + offset, taken modulo 2^20, so sums above 0xFFFFF wrap to the bottom of the space.
- R2: The access type code selects the segment register: 0 code, 1 data, 2 stack, 3 extra.
- R3: A byte request produces exactly one bus cycle. While bus_req is high and bus_ack is low, bus_addr, bus_we and bus_wdata hold steady.
- R4: A word request produces two bus cycles. The first uses the computed address and req_wdata[7:0]. The second uses that address plus one (mod 2^20) and req_wdata[15:8]. Read data is returned as {second byte, first byte}.
- R5: busy is high from the cycle after acceptance through the done cycle. done is high for exactly one cycle. That cycle follows the final acknowledge, or follows the restore for a far request.
- R6: A far request saves the selected segment and then loads req_far_seg into it. The access uses the loaded value, which the read port shows during the transfer. The saved value is restored before done.
- R7: A segment write while busy is low, or in the done cycle, is visible on the read port in the next cycle. A write while busy and not done is held per register, with the latest value kept, and becomes visible in the cycle after done.
- R8: req_valid is ignored while busy is high, and an ongoing bus sequence is not altered by it.
- R9: After reset, busy, done and bus_req are low and all segment registers read zero.
- R10: In the done cycle, rdata holds the read result. A byte read is zero-extended to 16 bits, and a write returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_seg | input | 2 | Access type / segment selector |
| req_offset | input | 16 | Offset within the segment |
| req_word | input | 1 | 1 = 16-bit transfer, 0 = byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data |
| req_far | input | 1 | Use a temporary segment value |
| req_far_seg | input | 16 | Segment value for a far request |
| seg_wr_en | input | 1 | Segment register write strobe |
| seg_wr_sel | input | 2 | Segment register to write |
| seg_wr_data | input | 16 | Value to write |
| seg_rd_sel | input | 2 | Segment register to show |
| seg_rd_data | output | 16 | Contents of the chosen register |
| bus_req | output | 1 | Bus cycle request |
| bus_addr | output | 20 | Physical byte address |
| bus_we | output | 1 | Bus write enable |
| bus_wdata | output | 8 | Bus write byte |
| bus_ack | input | 1 | Bus cycle acknowledge |
| bus_rdata | input | 8 | Bus read byte, sampled with bus_ack |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Read result |

## Verification
A wrong sequencer state shows on the bus pins at once. In the very cycle it occurs, a missing or extra bus cycle, a second byte at the wrong address, or a done pulse at the wrong point differs from what is expected. A corrupted segment register or a lost pending load appears on the read port one cycle later, and in the address of the next request that selects that register. A far request that fails to restore leaves the read port showing the temporary value from the cycle after done onward.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

    localparam int SEG_W_DEF  = 16;
    localparam int OFF_W_DEF  = 16;
    localparam int SHIFT_DEF  = 4;
    localparam int BUS_W_DEF  = 8;
    localparam int NSEG_DEF   = 4;

    // Access type codes; the sequencer indexes the register bank with them.
    typedef enum logic [1:0] {
        SEG_CODE  = 2'd0,
        SEG_DATA  = 2'd1,
        SEG_STACK = 2'd2,
        SEG_EXTRA = 2'd3
    } seg_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SAVE    = 3'd1,
        ST_LOAD    = 3'd2,
        ST_XFER0   = 3'd3,
        ST_XFER1   = 3'd4,
        ST_RESTORE = 3'd5,
        ST_FIN     = 3'd6
    } seq_state_e;

endpackage

// File: rtl/seg_bank.sv
module seg_bank #(
    parameter int SEG_W = seg_addr_pkg::SEG_W_DEF,
    parameter int NSEG  = seg_addr_pkg::NSEG_DEF,
    localparam int SEL_W = $clog2(NSEG)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       hold_i,
    input  logic                       commit_i,
    input  logic                       ext_we_i,
    input  logic [SEL_W-1:0]           ext_sel_i,
    input  logic [SEG_W-1:0]           ext_data_i,
    input  logic                       seq_we_i,
    input  logic [SEL_W-1:0]           seq_sel_i,
    input  logic [SEG_W-1:0]           seq_data_i,
    output logic [NSEG-1:0][SEG_W-1:0] segs_o
);

    typedef struct packed {
        logic [NSEG-1:0][SEG_W-1:0] segs;
        logic [NSEG-1:0]            pend_v;
        logic [NSEG-1:0][SEG_W-1:0] pend_d;
    } bank_t;

    bank_t q, d;

    always_comb begin
        d = q;
        // Sequencer save/restore traffic never coincides with a commit.
        if (seq_we_i) begin
            d.segs[seq_sel_i] = seq_data_i;
        end
        if (commit_i) begin
            for (int i = 0; i < NSEG; i++) begin
                if (q.pend_v[i]) begin
                    d.segs[i] = q.pend_d[i];
                end
            end
            d.pend_v = '0;
        end
        // External loads are newest, so they win over a committed slot.
        if (ext_we_i) begin
            if (hold_i) begin
                d.pend_v[ext_sel_i] = 1'b1;
                d.pend_d[ext_sel_i] = ext_data_i;
            end else begin
                d.segs[ext_sel_i] = ext_data_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign segs_o = q.segs;

endmodule

// File: rtl/seg_addr_calc.sv
module seg_addr_calc #(
    parameter int SEG_W  = seg_addr_pkg::SEG_W_DEF,
    parameter int OFF_W  = seg_addr_pkg::OFF_W_DEF,
    parameter int SHIFT  = seg_addr_pkg::SHIFT_DEF,
    localparam int ADDR_W = SEG_W + SHIFT
) (
    input  logic [SEG_W-1:0]  seg_i,
    input  logic [OFF_W-1:0]  off_i,
    input  logic              hi_i,
    output logic [ADDR_W-1:0] addr_o
);

    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] disp;

    assign base = {seg_i, {SHIFT{1'b0}}};

    generate
        if (OFF_W <= ADDR_W) begin : g_ext
            assign disp = ADDR_W'(off_i);
        end else begin : g_trunc
            assign disp = off_i[ADDR_W-1:0];
        end
    endgenerate

    // Carry out of the top bit is dropped: the space wraps.
    assign addr_o = base + disp + ADDR_W'(hi_i);

endmodule

// File: rtl/seg_bus_seq.sv
module seg_bus_seq
    import seg_addr_pkg::*;
#(
    parameter int SEG_W = SEG_W_DEF,
    parameter int OFF_W = OFF_W_DEF,
    parameter int BUS_W = BUS_W_DEF,
    parameter int NSEG  = NSEG_DEF,
    localparam int SEL_W = $clog2(NSEG),
    localparam int WRD_W = 2 * BUS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic [SEL_W-1:0]  req_sel_i,
    input  logic [OFF_W-1:0]  req_off_i,
    input  logic              req_word_i,
    input  logic              req_write_i,
    input  logic [WRD_W-1:0]  req_wdata_i,
    input  logic              req_far_i,
    input  logic [SEG_W-1:0]  req_far_seg_i,
    input  logic [SEG_W-1:0]  cur_seg_i,
    output logic [SEL_W-1:0]  sel_o,
    output logic [OFF_W-1:0]  off_o,
    output logic              hi_o,
    output logic              seq_we_o,
    output logic [SEG_W-1:0]  seq_data_o,
    output logic              bus_req_o,
    output logic              bus_we_o,
    output logic [BUS_W-1:0]  bus_wdata_o,
    input  logic              bus_ack_i,
    input  logic [BUS_W-1:0]  bus_rdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              hold_o,
    output logic              commit_o,
    output logic [WRD_W-1:0]  rdata_o
);

    typedef struct packed {
        seq_state_e        st;
        logic [SEL_W-1:0]  sel;
        logic [OFF_W-1:0]  off;
        logic              word;
        logic              write;
        logic              far;
        logic [WRD_W-1:0]  wdata;
        logic [SEG_W-1:0]  far_seg;
        logic [SEG_W-1:0]  save;
        logic [WRD_W-1:0]  rdata;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d = q;
        case (q.st)
            ST_IDLE: begin
                if (req_valid_i) begin
                    d.sel     = req_sel_i;
                    d.off     = req_off_i;
                    d.word    = req_word_i;
                    d.write   = req_write_i;
                    d.far     = req_far_i;
                    d.wdata   = req_wdata_i;
                    d.far_seg = req_far_seg_i;
                    d.rdata   = '0;
                    d.st      = req_far_i ? ST_SAVE : ST_XFER0;
                end
            end
            ST_SAVE: begin
                d.save = cur_seg_i;
                d.st   = ST_LOAD;
            end
            ST_LOAD: begin
                d.st = ST_XFER0;
            end
            ST_XFER0: begin
                if (bus_ack_i) begin
                    if (!q.write) begin
                        d.rdata[BUS_W-1:0] = bus_rdata_i;
                    end
                    if (q.word) begin
                        d.st = ST_XFER1;
                    end else begin
                        d.st = q.far ? ST_RESTORE : ST_FIN;
                    end
                end
            end
            ST_XFER1: begin
                if (bus_ack_i) begin
                    if (!q.write) begin
                        d.rdata[WRD_W-1:BUS_W] = bus_rdata_i;
                    end
                    d.st = q.far ? ST_RESTORE : ST_FIN;
                end
            end
            ST_RESTORE: begin
                d.st = ST_FIN;
            end
            ST_FIN: begin
                d.st = ST_IDLE;
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sel_o       = q.sel;
    assign off_o       = q.off;
    assign hi_o        = (q.st == ST_XFER1);
    assign seq_we_o    = (q.st == ST_LOAD) || (q.st == ST_RESTORE);
    assign seq_data_o  = (q.st == ST_LOAD) ? q.far_seg : q.save;
    assign bus_req_o   = (q.st == ST_XFER0) || (q.st == ST_XFER1);
    assign bus_we_o    = q.write;
    assign bus_wdata_o = hi_o ? q.wdata[WRD_W-1:BUS_W] : q.wdata[BUS_W-1:0];
    assign busy_o      = (q.st != ST_IDLE);
    assign done_o      = (q.st == ST_FIN);
    assign hold_o      = busy_o && !done_o;
    assign commit_o    = done_o;
    assign rdata_o     = q.rdata;

endmodule

// File: rtl/seg_addr_unit.sv
module seg_addr_unit #(
    parameter int SEG_W = seg_addr_pkg::SEG_W_DEF,
    parameter int OFF_W = seg_addr_pkg::OFF_W_DEF,
    parameter int SHIFT = seg_addr_pkg::SHIFT_DEF,
    parameter int BUS_W = seg_addr_pkg::BUS_W_DEF,
    parameter int NSEG  = seg_addr_pkg::NSEG_DEF,
    localparam int SEL_W  = $clog2(NSEG),
    localparam int ADDR_W = SEG_W + SHIFT,
    localparam int WRD_W  = 2 * BUS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [SEL_W-1:0]  req_seg,
    input  logic [OFF_W-1:0]  req_offset,
    input  logic              req_word,
    input  logic              req_write,
    input  logic [WRD_W-1:0]  req_wdata,
    input  logic              req_far,
    input  logic [SEG_W-1:0]  req_far_seg,
    input  logic              seg_wr_en,
    input  logic [SEL_W-1:0]  seg_wr_sel,
    input  logic [SEG_W-1:0]  seg_wr_data,
    input  logic [SEL_W-1:0]  seg_rd_sel,
    output logic [SEG_W-1:0]  seg_rd_data,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_we,
    output logic [BUS_W-1:0]  bus_wdata,
    input  logic              bus_ack,
    input  logic [BUS_W-1:0]  bus_rdata,
    output logic              busy,
    output logic              done,
    output logic [WRD_W-1:0]  rdata
);

    logic [NSEG-1:0][SEG_W-1:0] segs;
    logic [SEL_W-1:0]           sel;
    logic [OFF_W-1:0]           off;
    logic                       hi;
    logic                       seq_we;
    logic [SEG_W-1:0]           seq_data;
    logic                       hold;
    logic                       commit;
    logic [SEG_W-1:0]           cur_seg;

    assign cur_seg     = segs[sel];
    assign seg_rd_data = segs[seg_rd_sel];

    seg_bank #(
        .SEG_W (SEG_W),
        .NSEG  (NSEG)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_i     (hold),
        .commit_i   (commit),
        .ext_we_i   (seg_wr_en),
        .ext_sel_i  (seg_wr_sel),
        .ext_data_i (seg_wr_data),
        .seq_we_i   (seq_we),
        .seq_sel_i  (sel),
        .seq_data_i (seq_data),
        .segs_o     (segs)
    );

    seg_addr_calc #(
        .SEG_W (SEG_W),
        .OFF_W (OFF_W),
        .SHIFT (SHIFT)
    ) u_calc (
        .seg_i  (cur_seg),
        .off_i  (off),
        .hi_i   (hi),
        .addr_o (bus_addr)
    );

    seg_bus_seq #(
        .SEG_W (SEG_W),
        .OFF_W (OFF_W),
        .BUS_W (BUS_W),
        .NSEG  (NSEG)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid_i   (req_valid),
        .req_sel_i     (req_seg),
        .req_off_i     (req_offset),
        .req_word_i    (req_word),
        .req_write_i   (req_write),
        .req_wdata_i   (req_wdata),
        .req_far_i     (req_far),
        .req_far_seg_i (req_far_seg),
        .cur_seg_i     (cur_seg),
        .sel_o         (sel),
        .off_o         (off),
        .hi_o          (hi),
        .seq_we_o      (seq_we),
        .seq_data_o    (seq_data),
        .bus_req_o     (bus_req),
        .bus_we_o      (bus_we),
        .bus_wdata_o   (bus_wdata),
        .bus_ack_i     (bus_ack),
        .bus_rdata_i   (bus_rdata),
        .busy_o        (busy),
        .done_o        (done),
        .hold_o        (hold),
        .commit_o      (commit),
        .rdata_o       (rdata)
    );

endmodule

// File: rtl/seg_addr_unit_chk.sv
module seg_addr_unit_chk #(
    parameter int ADDR_W = 20,
    parameter int BUS_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              busy,
    input logic              done,
    input logic              bus_req,
    input logic              bus_ack,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [BUS_W-1:0]  bus_wdata
);

    p_req_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)))
        else $error("bus cycle changed before acknowledge");

    p_second_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack) |=> (!bus_req || (bus_addr == ADDR_W'($past(bus_addr) + 1'b1))))
        else $error("second byte not at next address");

    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("done longer than one cycle");

    p_done_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy)
        else $error("done without busy");

    p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> busy)
        else $error("idle request not taken");

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bus_req && !done))
        else $error("bus activity while idle");

endmodule

bind seg_addr_unit seg_addr_unit_chk #(
    .ADDR_W (ADDR_W),
    .BUS_W  (BUS_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .bus_req   (bus_req),
    .bus_ack   (bus_ack),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata)
);

// File: tb/seg_addr_unit_tb.sv
`timescale 1ns/1ps
module seg_addr_unit_tb;

    localparam int K_SAVE = 1, K_LOAD = 2, K_B0 = 3, K_B1 = 4, K_REST = 5, K_FIN = 6;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_word, req_write, req_far;
    logic [1:0]  req_seg;
    logic [15:0] req_offset, req_wdata, req_far_seg;
    logic        seg_wr_en;
    logic [1:0]  seg_wr_sel, seg_rd_sel;
    logic [15:0] seg_wr_data, seg_rd_data;
    logic        bus_req, bus_we, bus_ack;
    logic [19:0] bus_addr;
    logic [7:0]  bus_wdata, bus_rdata;
    logic        busy, done;
    logic [15:0] rdata;

    always #2 clk = ~clk;

    seg_addr_unit u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_seg(req_seg),
        .req_offset(req_offset), .req_word(req_word), .req_write(req_write),
        .req_wdata(req_wdata), .req_far(req_far), .req_far_seg(req_far_seg),
        .seg_wr_en(seg_wr_en), .seg_wr_sel(seg_wr_sel), .seg_wr_data(seg_wr_data),
        .seg_rd_sel(seg_rd_sel), .seg_rd_data(seg_rd_data), .bus_req(bus_req),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .busy(busy), .done(done),
        .rdata(rdata)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    int cyc_cnt = 0;

    // Reference model state
    logic [7:0]  mem [int];
    logic [15:0] m_seg [4];
    bit          m_pv  [4];
    logic [15:0] m_pd  [4];
    int          steps [$];
    int          m_sel;
    logic [15:0] m_off, m_wdata, m_farseg, m_save, m_rd;
    bit          m_word, m_write, m_far;
    int          ack_lat = 0;
    int          ack_seed = 0;
    int          acked [$];
    int          done_cnt;
    logic [15:0] done_data, seg_seen;

    function automatic logic [7:0] memrd(input int a);
        if (mem.exists(a)) return mem[a];
        return 8'((a * 37 + 11) ^ (a >> 8));
    endfunction

    function automatic int cur_step();
        return (steps.size() != 0) ? steps[0] : 0;
    endfunction

    function automatic logic [19:0] exp_addr();
        int a;
        a = (int'(m_seg[m_sel]) * 16 + int'(m_off) + ((cur_step() == K_B1) ? 1 : 0)) % 1048576;
        return 20'(a);
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model_update();
        int  s;
        bit  hold;
        int  a;
        s = cur_step();
        hold = (s != 0) && (s != K_FIN);
        if (s == K_SAVE) begin
            m_save = m_seg[m_sel]; void'(steps.pop_front());
        end else if (s == K_LOAD) begin
            m_seg[m_sel] = m_farseg; void'(steps.pop_front());
        end else if (s == K_B0 || s == K_B1) begin
            if (bus_ack) begin
                a = int'(exp_addr());
                if (m_write) mem[a] = (s == K_B1) ? m_wdata[15:8] : m_wdata[7:0];
                else if (s == K_B0) m_rd[7:0] = bus_rdata;
                else m_rd[15:8] = bus_rdata;
                void'(steps.pop_front());
            end
        end else if (s == K_REST) begin
            m_seg[m_sel] = m_save; void'(steps.pop_front());
        end else if (s == K_FIN) begin
            for (int i = 0; i < 4; i++) begin
                if (m_pv[i]) m_seg[i] = m_pd[i];
                m_pv[i] = 0;
            end
            void'(steps.pop_front());
        end else if (req_valid) begin
            m_sel = int'(req_seg); m_off = req_offset; m_word = req_word;
            m_write = req_write; m_wdata = req_wdata; m_far = req_far;
            m_farseg = req_far_seg; m_rd = '0;
            if (m_far) begin steps.push_back(K_SAVE); steps.push_back(K_LOAD); end
            steps.push_back(K_B0);
            if (m_word) steps.push_back(K_B1);
            if (m_far) steps.push_back(K_REST);
            steps.push_back(K_FIN);
        end
        if (seg_wr_en) begin
            if (hold) begin
                m_pv[seg_wr_sel] = 1; m_pd[seg_wr_sel] = seg_wr_data;
            end else begin
                m_seg[seg_wr_sel] = seg_wr_data;
            end
        end
    endtask

    task automatic compare_all();
        int s;
        s = cur_step();
        chk("R5", "busy", 32'(busy), 32'(s != 0));
        chk("R5", "done", 32'(done), 32'(s == K_FIN));
        chk("R3", "bus_req", 32'(bus_req), 32'(s == K_B0 || s == K_B1));
        if (s == K_B0 || s == K_B1) begin
            chk("R1", "bus_addr", 32'(bus_addr), 32'(exp_addr()));
            chk("R3", "bus_we", 32'(bus_we), 32'(m_write));
            chk("R4", "bus_wdata", 32'(bus_wdata),
                32'((s == K_B1) ? m_wdata[15:8] : m_wdata[7:0]));
        end
        chk("R7", "seg_rd_data", 32'(seg_rd_data), 32'(m_seg[seg_rd_sel]));
        if (s == K_FIN) chk("R10", "rdata", 32'(rdata), 32'(m_rd));
    endtask

    // Called at a falling edge; advances one clock.
    task automatic cyc();
        int s;
        s = cur_step();
        if (s == K_B0 || s == K_B1) begin
            bus_ack   = (ack_lat == 0);
            bus_rdata = memrd(int'(exp_addr()));
            if (ack_lat == 0) begin
                acked.push_back(int'(bus_addr));
                ack_seed++;
                ack_lat = ack_seed % 3;
            end else begin
                ack_lat--;
            end
        end else begin
            bus_ack = 1'b0; bus_rdata = 8'h00;
        end
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare_all();
    endtask

    task automatic seg_load(input logic [1:0] sel, input logic [15:0] val);
        seg_wr_en = 1; seg_wr_sel = sel; seg_wr_data = val;
        cyc();
        seg_wr_en = 0;
    endtask

    // Issues one request; optional mid-transfer segment write and busy-time request noise.
    task automatic run_req(input logic [1:0] sel, input logic [15:0] off, input bit word,
                           input bit write, input logic [15:0] wd, input bit far,
                           input logic [15:0] fseg, input bit mid_wr,
                           input logic [1:0] mid_sel, input logic [15:0] mid_val,
                           input bit noise);
        int n;
        acked.delete();
        done_cnt = 0;
        req_valid = 1; req_seg = sel; req_offset = off; req_word = word;
        req_write = write; req_wdata = wd; req_far = far; req_far_seg = fseg;
        cyc();
        req_valid = 0;
        seg_seen = 16'hxxxx;
        n = 0;
        while (!done && n < 40) begin
            if (bus_req && n == 0) seg_seen = seg_rd_data;
            if (mid_wr && n == 0) begin
                seg_wr_en = 1; seg_wr_sel = mid_sel; seg_wr_data = mid_val;
            end else begin
                seg_wr_en = 0;
            end
            if (noise) begin
                req_valid = 1; req_seg = 2'd3; req_offset = 16'h7777;
                req_word = 1; req_write = 1; req_far = 0;
            end
            cyc();
            req_valid = 0;
            n++;
        end
        seg_wr_en = 0;
        req_valid = 0;
        if (n >= 40) chk("R5", "request timeout", 32'd0, 32'd1);
        done_cnt = done ? 1 : 0;
        done_data = rdata;
        cyc();
        if (done) done_cnt++;
    endtask

    initial begin
        rst_n = 0;
        req_valid = 0; req_seg = 0; req_offset = 0; req_word = 0; req_write = 0;
        req_wdata = 0; req_far = 0; req_far_seg = 0;
        seg_wr_en = 0; seg_wr_sel = 0; seg_wr_data = 0; seg_rd_sel = 0;
        bus_ack = 0; bus_rdata = 0;
        for (int i = 0; i < 4; i++) begin m_seg[i] = 0; m_pv[i] = 0; m_pd[i] = 0; end
        m_sel = 0; m_off = 0; m_wdata = 0; m_farseg = 0; m_save = 0; m_rd = 0;
        m_word = 0; m_write = 0; m_far = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R9: reset state
        chk("R9", "busy after reset", 32'(busy), 32'd0);
        chk("R9", "done after reset", 32'(done), 32'd0);
        chk("R9", "bus_req after reset", 32'(bus_req), 32'd0);
        for (int i = 0; i < 4; i++) begin
            seg_rd_sel = 2'(i);
            #0;
            chk("R9", "segment after reset", 32'(seg_rd_data), 32'd0);
        end

        // R7: idle loads visible next cycle
        seg_rd_sel = 2'd1;
        seg_load(2'd0, 16'h1234);
        seg_load(2'd1, 16'h2000);
        chk("R7", "idle load visible next cycle", 32'(seg_rd_data), 32'h2000);
        seg_load(2'd2, 16'hFFFF);
        seg_load(2'd3, 16'h0F00);

        // R2/R3/R10: code byte read
        run_req(2'd0, 16'h0005, 0, 0, 16'h0, 0, 16'h0, 0, 2'd0, 16'h0, 0);
        chk("R3", "byte bus cycles", 32'(acked.size()), 32'd1);
        chk("R2", "code segment address", 32'(acked[0]), 32'h12345);
        chk("R10", "byte read zero-extended", 32'(done_data), 32'({8'h00, memrd(32'h12345)}));
        chk("R5", "done cycles", 32'(done_cnt), 32'd1);

        // R2: extra segment
        run_req(2'd3, 16'h00FF, 0, 0, 16'h0, 0, 16'h0, 0, 2'd0, 16'h0, 0);
        chk("R2", "extra segment address", 32'(acked[0]), 32'h0F0FF);

        // R1/R4: stack word write that wraps past the top
        run_req(2'd2, 16'h0010, 1, 1, 16'hBEEF, 0, 16'h0, 0, 2'd0, 16'h0, 0);
        chk("R4", "word bus cycles", 32'(acked.size()), 32'd2);
        chk("R1", "wrapped low byte address", 32'(acked[0]), 32'h00000);
        chk("R4", "high byte address", 32'(acked[1]), 32'h00001);
        chk("R10", "write returns zero", 32'(done_data), 32'h0);

        // R6/R4: far word read of the bytes just written
        seg_rd_sel = 2'd1;
        run_req(2'd1, 16'h0000, 1, 0, 16'h0, 1, 16'h0000, 0, 2'd0, 16'h0, 0);
        chk("R6", "far value during access", 32'(seg_seen), 32'h0000);
        chk("R4", "word read byte order", 32'(done_data), 32'hBEEF);
        chk("R6", "data segment restored", 32'(seg_rd_data), 32'h2000);

        // R1/R4: far word read at the last byte, high byte wraps to zero
        run_req(2'd1, 16'hFFFF, 1, 0, 16'h0, 1, 16'hF000, 0, 2'd0, 16'h0, 0);
        chk("R1", "top of space", 32'(acked[0]), 32'hFFFFF);
        chk("R4", "high byte wraps", 32'(acked[1]), 32'h00000);
        chk("R4", "wrapped word data", 32'(done_data), 32'({8'hEF, memrd(32'hFFFFF)}));

        // R7: load during transfer is held
        run_req(2'd1, 16'h0003, 0, 1, 16'h005A, 0, 16'h0, 1, 2'd1, 16'h2100, 0);
        chk("R2", "data segment address", 32'(acked[0]), 32'h20003);
        chk("R7", "held load not visible during transfer", 32'(seg_seen), 32'h2000);
        chk("R7", "held load applied after done", 32'(seg_rd_data), 32'h2100);

        // R6/R7: load to the swapped register during a far access wins after restore
        seg_rd_sel = 2'd2;
        run_req(2'd2, 16'h0020, 0, 0, 16'h0, 1, 16'h4000, 1, 2'd2, 16'h1111, 0);
        chk("R6", "far stack address", 32'(acked[0]), 32'h40020);
        chk("R7", "held load beats restore", 32'(seg_rd_data), 32'h1111);

        // R8: requests while busy are ignored
        run_req(2'd0, 16'h0100, 0, 0, 16'h0, 0, 16'h0, 0, 2'd0, 16'h0, 1);
        chk("R8", "bus cycles with busy-time requests", 32'(acked.size()), 32'd1);
        chk("R8", "address unaffected", 32'(acked[0]), 32'h12440);
        chk("R8", "idle after run", 32'(busy), 32'd0);

        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    always @(posedge clk) begin
        cyc_cnt++;
        if (cyc_cnt > 150000 && !finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL R5 watchdog actual=%0d expected=%0d", cyc_cnt, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule